// File: doc/BRIEF.md
# Ring Convolution Encryption Engine

This block produces the ciphertext polynomial of a lattice-based public-key encryption. It computes c(x) = r(x) ⊛ h'(x) + m(x) mod 128 in the ring of polynomials of degree below N (default 167), where ⊛ is cyclic convolution. Coefficient k of the product is the sum of h'_i · r_j over all index pairs with i + j ≡ k (mod N). The random polynomial r and the message m carry ternary coefficients. The key h' is a fixed public key that is already scaled by p = 3. It lives in combinational lookup logic, so the engine stores no key.

The random polynomial is shifted serially into a ring buffer of 2N bits while the engine is idle. After a start pulse, a controller sweeps the key index upward, one step per cycle. At the same time the ring buffer rotates, so each arithmetic unit sees the random-polynomial index running downward. K arithmetic units each accumulate one coefficient per round, in carry-save form. A round has N multiply-accumulate cycles, then one cycle that adds the message coefficient, then QW cycles that absorb the saved carries. The K results of a round drain out through a short shift register, one per cycle, each with a valid strobe and its coefficient index.

The controller is a five-state machine:
- IDLE goes to MAC on start.
- MAC goes to MSG after N cycles.
- MSG goes to SETTLE after one cycle.
- SETTLE goes back to MAC (next round), to FLUSH (last round with K > 1) or to IDLE (last round with K = 1) after QW cycles.
- FLUSH goes to IDLE after K−1 cycles.

Top module: `ring_conv_engine`

## Requirements
- R1: After reset, busy and out_valid are low.
- R2: While idle, each cycle with phi_load high shifts phi_code into the ring buffer. The first of N consecutive loads becomes coefficient r_0 and the last becomes r_(N−1). Loads while busy are ignored, and the buffer content survives a job unchanged.
- R3: Ternary codes are 2'b00 = 0, 2'b01 = +1 and 2'b11 = −1. The code 2'b10 counts as 0. This holds for both phi_code and msg_code.
- R4: Key coefficient i is h'_i = 3·(i² + 3i + 7) mod 128.
- R5: Output coefficient k equals (Σ h'_i · r_j over i + j ≡ k mod N) + m_k, reduced mod 128 and presented as 7 bits.
- R6: msg_take is high for exactly one cycle per round. In that cycle, lane u of msg_code (bits 2u+1:2u) must carry m_(msg_base+u). Lanes whose index is N or more are unused.
- R7: Let the start edge be edge 0. Coefficient r·K + u (round r, lane u) is presented with out_valid in the cycle after rising edge (N+8)(r+1)+u, together with its index on out_idx.
- R8: busy rises on the start edge and falls on edge (N+8)·⌈N/K⌉ + K − 1. For K = 1 and N = 167 that is edge 29,225. No valid output appears once busy has been low for a cycle.
- R9: A start pulse while busy has no effect on the job in progress or on its outputs.
- R10: In the last round, lanes whose index would reach N or more produce no valid output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (sampled when idle) |
| phi_load | input | 1 | Shift phi_code into the ring buffer (idle only) |
| phi_code | input | 2 | Ternary random coefficient to load |
| msg_code | input | 2·K | Ternary message coefficients, one lane per unit |
| msg_take | output | 1 | Message lanes are sampled in this cycle |
| msg_base | output | IW | Coefficient index for message lane 0 |
| busy | output | 1 | Job in progress |
| out_valid | output | 1 | out_coef/out_idx hold a result |
| out_coef | output | 7 | Ciphertext coefficient |
| out_idx | output | IW | Index of out_coef |

## Verification
The bench builds two copies side by side with N = 167. One has K = 1, which reaches the exact 29,225-cycle job length and the serial output timing. The other has K = 4, which brings in the drain register, the FLUSH state and a last round in which one lane falls beyond N−1 (167 is not a multiple of 4). Both copies receive identical stimulus:
- a single-term random polynomial, padded with the unused code, whose output is a rotated copy of the key;
- a dense random case;
- an all −1 case, during which loads and starts are issued mid-job;
- a rerun without reloading the buffer.

// File: rtl/ring_conv_pkg.sv
package ring_conv_pkg;

    typedef logic [1:0] tern_t;

    localparam tern_t TERN_ZERO = 2'b00;
    localparam tern_t TERN_POS  = 2'b01;
    localparam tern_t TERN_NEG  = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MAC,
        ST_MSG,
        ST_SETTLE,
        ST_FLUSH
    } eng_state_t;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_MAC,
        OP_MSG,
        OP_SETTLE
    } au_op_t;

    // Unscaled public key coefficient generator; the lookup is pure logic.
    function automatic int key_base(input int idx);
        return idx * idx + 3 * idx + 7;
    endfunction

endpackage

// File: rtl/ring_phi_buf.sv
module ring_phi_buf
    import ring_conv_pkg::*;
#(
    parameter int N    = 167,
    parameter int TAPS = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_en,
    input  tern_t                 shift_in,
    input  logic                  rotate,
    output logic [TAPS-1:0][1:0]  taps
);

    tern_t cell_q [N];

    // Serial fill moves toward cell 0; rotation moves toward cell N-1
    // and closes the ring through cell 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) cell_q[i] <= TERN_ZERO;
        end else if (shift_en) begin
            for (int i = 0; i < N - 1; i++) cell_q[i] <= cell_q[i+1];
            cell_q[N-1] <= shift_in;
        end else if (rotate) begin
            cell_q[0] <= cell_q[N-1];
            for (int i = 1; i < N; i++) cell_q[i] <= cell_q[i-1];
        end
    end

    for (genvar u = 0; u < TAPS; u++) begin : g_tap
        assign taps[u] = cell_q[u];
    end

endmodule

// File: rtl/conv_mac_unit.sv
module conv_mac_unit
    import ring_conv_pkg::*;
#(
    parameter int QW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  au_op_t        op,
    input  logic [QW-1:0] key_coef,
    input  tern_t         phi_code,
    input  tern_t         msg_code,
    output logic [QW-1:0] result
);

    logic [QW-1:0] sum_q, car_q;
    logic [QW-1:0] pp, maj;

    function automatic logic [QW-1:0] tern_scale(input logic [QW-1:0] a, input tern_t t);
        case (t)
            TERN_POS: return a;
            TERN_NEG: return ~a + QW'(1);
            default:  return '0;
        endcase
    endfunction

    always_comb begin
        unique case (op)
            OP_MAC:  pp = tern_scale(key_coef, phi_code);
            OP_MSG:  pp = tern_scale(QW'(1), msg_code);
            default: pp = '0;
        endcase
        maj = (sum_q & car_q) | (sum_q & pp) | (car_q & pp);
    end

    // Carry-save accumulation; carries leaving bit QW-1 are dropped (mod 2^QW).
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum_q <= '0;
            car_q <= '0;
        end else if (op != OP_HOLD) begin
            sum_q <= sum_q ^ car_q ^ pp;
            car_q <= {maj[QW-2:0], 1'b0};
        end
    end

    assign result = sum_q ^ car_q;

endmodule

// File: rtl/conv_out_drain.sv
module conv_out_drain #(
    parameter int N  = 167,
    parameter int K  = 1,
    parameter int QW = 7,
    parameter int IW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [IW-1:0]         base,
    input  logic [K-1:0][QW-1:0]  res,
    output logic                  out_valid,
    output logic [QW-1:0]         out_coef,
    output logic [IW-1:0]         out_idx
);

    logic [K-1:0]          vld_q;
    logic [K-1:0][QW-1:0]  dat_q;
    logic [K-1:0][IW-1:0]  idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            dat_q <= '0;
            idx_q <= '0;
        end else if (load) begin
            for (int u = 0; u < K; u++) begin
                dat_q[u] <= res[u];
                idx_q[u] <= base + IW'(u);
                vld_q[u] <= (int'(base) + u < N);
            end
        end else begin
            for (int u = 0; u < K; u++) begin
                if (u < K - 1) begin
                    dat_q[u] <= dat_q[u+1];
                    idx_q[u] <= idx_q[u+1];
                    vld_q[u] <= vld_q[u+1];
                end else begin
                    dat_q[u] <= '0;
                    idx_q[u] <= '0;
                    vld_q[u] <= 1'b0;
                end
            end
        end
    end

    assign out_valid = vld_q[0];
    assign out_coef  = dat_q[0];
    assign out_idx   = idx_q[0];

endmodule

// File: rtl/ring_conv_engine.sv
module ring_conv_engine
    import ring_conv_pkg::*;
#(
    parameter int N       = 167,
    parameter int K       = 1,
    parameter int QW      = 7,
    parameter int P_SCALE = 3,
    parameter int IW      = $clog2(N + K + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            phi_load,
    input  logic [1:0]      phi_code,
    input  logic [2*K-1:0]  msg_code,
    output logic            msg_take,
    output logic [IW-1:0]   msg_base,
    output logic            busy,
    output logic            out_valid,
    output logic [QW-1:0]   out_coef,
    output logic [IW-1:0]   out_idx
);

    localparam int SETTLE_LEN = QW;
    localparam int CW         = $clog2(N + SETTLE_LEN + K + 2);

    eng_state_t st_q, st_nx;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] base_q, kidx_q;
    logic          last_round, round_end, job_go;
    logic          buf_shift, buf_rot, au_clr;
    au_op_t        au_op;
    logic [QW-1:0] key_coef;
    logic [K-1:0][1:0]     phi_taps;
    logic [K-1:0][QW-1:0]  au_res;

    assign last_round = (int'(base_q) + K >= N);
    assign round_end  = (st_q == ST_SETTLE) && (int'(cnt_q) == SETTLE_LEN - 1);
    assign job_go     = (st_q == ST_IDLE) && start;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    // Next-state logic
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE:   if (start) st_nx = ST_MAC;
            ST_MAC:    if (int'(cnt_q) == N - 1) st_nx = ST_MSG;
            ST_MSG:    st_nx = ST_SETTLE;
            ST_SETTLE: if (round_end) begin
                           if (!last_round)  st_nx = ST_MAC;
                           else if (K > 1)   st_nx = ST_FLUSH;
                           else              st_nx = ST_IDLE;
                       end
            ST_FLUSH:  if (int'(cnt_q) == K - 2) st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // Step counter and loop indices
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            base_q <= '0;
            kidx_q <= '0;
        end else begin
            cnt_q <= (st_nx != st_q) ? '0 : cnt_q + CW'(1);
            if (job_go) begin
                base_q <= '0;
                kidx_q <= '0;
            end else if (round_end && !last_round) begin
                base_q <= base_q + IW'(K);
                kidx_q <= base_q + IW'(K);
            end else if (st_q == ST_MAC) begin
                kidx_q <= (int'(kidx_q) == N - 1) ? '0 : kidx_q + IW'(1);
            end
        end
    end

    // Outputs and datapath controls
    always_comb begin
        busy      = (st_q != ST_IDLE);
        msg_take  = (st_q == ST_MSG);
        buf_shift = (st_q == ST_IDLE) && phi_load && !start;
        buf_rot   = (st_q == ST_MAC);
        au_clr    = job_go || round_end;
        unique case (st_q)
            ST_MAC:    au_op = OP_MAC;
            ST_MSG:    au_op = OP_MSG;
            ST_SETTLE: au_op = OP_SETTLE;
            default:   au_op = OP_HOLD;
        endcase
    end

    assign msg_base = base_q;
    assign key_coef = QW'(P_SCALE * key_base(int'(kidx_q)));

    ring_phi_buf #(.N(N), .TAPS(K)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (buf_shift),
        .shift_in (phi_code),
        .rotate   (buf_rot),
        .taps     (phi_taps)
    );

    for (genvar u = 0; u < K; u++) begin : g_au
        conv_mac_unit #(.QW(QW)) u_au (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (au_clr),
            .op       (au_op),
            .key_coef (key_coef),
            .phi_code (phi_taps[u]),
            .msg_code (msg_code[2*u +: 2]),
            .result   (au_res[u])
        );
    end

    conv_out_drain #(.N(N), .K(K), .QW(QW), .IW(IW)) u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (round_end),
        .base      (base_q),
        .res       (au_res),
        .out_valid (out_valid),
        .out_coef  (out_coef),
        .out_idx   (out_idx)
    );

endmodule

// File: rtl/ring_conv_engine_chk.sv
module ring_conv_engine_chk #(
    parameter int N  = 167,
    parameter int IW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          msg_take,
    input logic          out_valid,
    input logic [IW-1:0] out_idx
);

    assert_idx_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_idx) < N));

    assert_take_in_job_R6: assert property (@(posedge clk) disable iff (!rst_n)
        msg_take |-> busy);

    assert_take_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        msg_take |=> !msg_take);

    assert_idx_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (out_idx == $past(out_idx) + IW'(1)));

    assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> !out_valid);

endmodule

bind ring_conv_engine ring_conv_engine_chk #(.N(N), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .msg_take  (msg_take),
    .out_valid (out_valid),
    .out_idx   (out_idx)
);

// File: tb/ring_conv_engine_tb.sv
module ring_conv_engine_tb;

    localparam int N  = 167;
    localparam int QW = 7;
    localparam int IW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic phi_load = 1'b0;
    logic [1:0] phi_code = 2'b00;
    logic [1:0] msg_a = 2'b00;
    logic [7:0] msg_b = 8'h00;

    logic          take_a, busy_a, val_a;
    logic [IW-1:0] base_a, idx_a;
    logic [QW-1:0] coef_a;
    logic          take_b, busy_b, val_b;
    logic [IW-1:0] base_b, idx_b;
    logic [QW-1:0] coef_b;

    always #2 clk = ~clk;

    ring_conv_engine #(.N(N), .K(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .phi_load(phi_load),
        .phi_code(phi_code), .msg_code(msg_a), .msg_take(take_a),
        .msg_base(base_a), .busy(busy_a), .out_valid(val_a),
        .out_coef(coef_a), .out_idx(idx_a));

    ring_conv_engine #(.N(N), .K(4)) u_dut_par (
        .clk(clk), .rst_n(rst_n), .start(start), .phi_load(phi_load),
        .phi_code(phi_code), .msg_code(msg_b), .msg_take(take_b),
        .msg_base(base_b), .busy(busy_b), .out_valid(val_b),
        .out_coef(coef_b), .out_idx(idx_b));

    logic [1:0] phi_enc [N];
    logic [1:0] msg_enc [N];
    int exp_c [N];
    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    int start_cyc = 0;
    bit running = 1'b0;
    string job_tag = "";

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int tern_val(input logic [1:0] c);
        if (c == 2'b01) return 1;
        if (c == 2'b11) return -1;
        return 0;
    endfunction

    // R4: pre-scaled key value.
    function automatic int key_ref(input int i);
        return (3 * ((i * i + 3 * i + 7) % 128)) % 128;
    endfunction

    function automatic logic [1:0] lane_code(input int ix);
        if (ix < N) return msg_enc[ix];
        return 2'b00;
    endfunction

    // Message lanes answer the engine's requested base (R6).
    always @(negedge clk) begin
        msg_a <= lane_code(int'(base_a));
        for (int u = 0; u < 4; u++) msg_b[2*u +: 2] <= lane_code(int'(base_b) + u);
    end

    function automatic int job_len(input int k);
        return (N + 8) * ((N + k - 1) / k) + k - 1;
    endfunction

    task automatic check_one(input int k, input int d, input logic v, input logic [IW-1:0] ix,
                             input logic [QW-1:0] cf, input logic bz);
        int t;
        bit ev;
        int eix;
        t = job_len(k);
        if (d > t + 2) return;
        ev = 1'b0;
        eix = 0;
        for (int u = 0; u < k; u++) begin
            if (d - u > 0 && (d - u) % (N + 8) == 0) begin
                int r;
                r = (d - u) / (N + 8) - 1;
                if (r * k + u < N) begin
                    ev = 1'b1;
                    eix = r * k + u;
                end
            end
        end
        vectors++;
        if (bz !== (d < t)) begin
            fails++;
            $display("FAIL R8 K=%0d d=%0d busy actual=%0b expected=%0b", k, d, bz, (d < t));
        end
        if (v !== ev) begin
            fails++;
            $display("FAIL R7 R10 K=%0d d=%0d out_valid actual=%0b expected=%0b", k, d, v, ev);
        end else if (ev) begin
            if (int'(ix) != eix) begin
                fails++;
                $display("FAIL R7 K=%0d d=%0d out_idx actual=%0d expected=%0d", k, d, ix, eix);
            end else if (int'(cf) != exp_c[eix]) begin
                fails++;
                $display("FAIL %s K=%0d coef[%0d] actual=%0d expected=%0d",
                         job_tag, k, eix, cf, exp_c[eix]);
            end
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            check_one(1, cyc - start_cyc, val_a, idx_a, coef_a, busy_a);
            check_one(4, cyc - start_cyc, val_b, idx_b, coef_b, busy_b);
        end
    end

    // R5 reference: cyclic convolution plus message, mod 128.
    task automatic compute_expected();
        for (int k = 0; k < N; k++) begin
            int acc;
            acc = tern_val(msg_enc[k]);
            for (int i = 0; i < N; i++)
                acc += key_ref(i) * tern_val(phi_enc[(k - i + N) % N]);
            exp_c[k] = ((acc % 128) + 128) % 128;
        end
    endtask

    // R2: first load becomes coefficient 0.
    task automatic load_phi();
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            phi_load = 1'b1;
            phi_code = phi_enc[i];
        end
        @(negedge clk);
        phi_load = 1'b0;
        phi_code = 2'b00;
    endtask

    task automatic run_job(input bit poke);
        compute_expected();
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1;
        start_cyc = cyc;
        running = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R2/R9: loads and a start while busy must change nothing.
            repeat (500) @(negedge clk);
            phi_load = 1'b1;
            phi_code = 2'b01;
            repeat (5) @(negedge clk);
            phi_load = 1'b0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (cyc - start_cyc <= job_len(1) + 3) @(negedge clk);
        running = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(77));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        vectors++;
        if (busy_a !== 1'b0 || val_a !== 1'b0 || busy_b !== 1'b0 || val_b !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset busy/valid actual=%0b%0b%0b%0b expected=0000",
                     busy_a, val_a, busy_b, val_b);
        end

        // Job 1: single +1 at index 1, rest uses the unused code 10 or 00 (R3, R4, R6).
        for (int i = 0; i < N; i++) begin
            phi_enc[i] = (i == 1) ? 2'b01 : ((i % 3 == 0) ? 2'b10 : 2'b00);
            msg_enc[i] = 2'($urandom_range(0, 3));
        end
        job_tag = "R3 R4 R5 R6";
        load_phi();
        run_job(1'b0);

        // Job 2: dense random polynomials (R5).
        for (int i = 0; i < N; i++) begin
            phi_enc[i] = 2'($urandom_range(0, 3));
            msg_enc[i] = 2'($urandom_range(0, 3));
        end
        job_tag = "R3 R5";
        load_phi();
        run_job(1'b0);

        // Job 3: all -1 with pokes while busy (R9).
        for (int i = 0; i < N; i++) begin
            phi_enc[i] = 2'b11;
            msg_enc[i] = 2'b01;
        end
        job_tag = "R5 R9";
        load_phi();
        run_job(1'b1);

        // Job 4: no reload; buffer must be intact after a job and busy loads (R2).
        for (int i = 0; i < N; i++) msg_enc[i] = 2'($urandom_range(0, 3));
        job_tag = "R2 R5";
        run_job(1'b0);

        finish_run();
    end

endmodule